// File: doc/BRIEF.md
# Display Command Stream Register Decoder

The decoder sits on a byte stream of display-controller commands. It takes one byte per valid/ready handshake and finds the commands in it. Each command opens with a fixed escape byte, followed by an opcode. Register-write commands land in a shadow file of byte-wide registers. An active copy of that file feeds the video timing logic, and the decoder also presents the multi-byte fields that the timing logic reads: colour depth, two plane base pointers and the pixel clock.

A register-level lock protects multi-register updates. Writing the lock value to the control register freezes the active set, so later writes reach only the shadow file. Writing the unlock value copies the whole shadow file into the active set in a single cycle and pulses a commit strobe. When the decoder is unlocked, a write updates both copies at once.

Copy commands are recognised and their seven operand bytes are skipped without any register effect. Unknown opcodes and stray bytes outside a command are dropped.

Top module: `disp_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it is released, every active register reads 0x00 and commit_o is low. ready_o is always high.
- R2: When unlocked, the sequence 0xAF, 0x20, A, D (A not 0xFF) sets active register A to D, visible on regs_o[A*8 +: 8] in the cycle after the handshake of D.
- R3: While locked, register writes change the shadow file only, and regs_o stays unchanged.
- R4: The write 0xAF, 0x20, 0xFF, 0xFF (unlock) copies every shadow register into the active set at once, and commit_o is high for exactly the one cycle after the handshake of the final 0xFF. The write 0xAF, 0x20, 0xFF, 0x00 locks.
- R5: A handshaked byte other than 0xAF, at a point where a command should begin, is discarded with no register effect, and the next 0xAF starts a command.
- R6: After 0xAF, any opcode other than 0x20 or 0x6A (0xAF included) returns the decoder to idle without writing, and the bytes that follow are parsed as new command starts.
- R7: Opcode 0x6A is followed by exactly 7 operand bytes. These are skipped even when they contain 0xAF or 0x20, and decoding resumes with the byte after them.
- R8: base16_o = {reg 0x20, reg 0x21, reg 0x22} and base8_o = {reg 0x26, reg 0x27, reg 0x28}, with the first register as the most significant byte.
- R9: pix_clk_o = {reg 0x1C, reg 0x1B}, with the low byte at 0x1B. depth_o = bit 0 of reg 0x00, where 0 means 16 bpp and 1 means 24 bpp.
- R10: Register 0xFF always reads 0x00 on regs_o. A write to it with a value other than 0x00 or 0xFF changes neither the registers nor the lock state.
- R11: A byte without valid_i is ignored, and the parse position holds across idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte present on byte_i |
| byte_i | input | 8 | Command stream byte |
| ready_o | output | 1 | Byte accepted (always high) |
| regs_o | output | NUM_REGS*8 | Active register set, register k at bits k*8 +: 8 |
| commit_o | output | 1 | One-cycle pulse after an unlock copy |
| depth_o | output | 1 | Colour depth select (0: 16 bpp, 1: 24 bpp) |
| base16_o | output | 24 | 16-bpp plane base pointer |
| base8_o | output | 24 | 8-bpp plane base pointer |
| pix_clk_o | output | 16 | Pixel clock value |

## Verification
Some properties hold on every cycle, and the assertions check those:
- While locked, the active set stays frozen unless a commit is taking place.
- commit_o is a single-cycle pulse, and it only follows an unlock write.
- The skip state never writes.
- Stray bytes and unknown opcodes always leave the parser idle.
- Register 0xFF always reads zero.
- The parse position holds while valid_i is low.

Other behaviour needs the bench's scenarios and its cycle-by-cycle reference model. Those scenarios show that the committed values are the exact set written during the lock window. They show that copy operands hiding escape/opcode patterns are skipped, and that the multi-byte fields assemble in the right byte order.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;
  localparam logic [7:0] ESC_BYTE   = 8'hAF;
  localparam logic [7:0] OP_REG_WR  = 8'h20;
  localparam logic [7:0] OP_COPY    = 8'h6A;
  localparam logic [7:0] LOCK_VAL   = 8'h00;
  localparam logic [7:0] UNLOCK_VAL = 8'hFF;
  localparam int unsigned COPY_OPERANDS = 7;
  localparam int unsigned SKIP_W = $clog2(COPY_OPERANDS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } dec_state_e;
endpackage

// File: rtl/disp_cmd_parser.sv
module disp_cmd_parser
  import disp_cmd_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [7:0]    byte_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output dec_state_e    state_o
);
  dec_state_e        state_q;
  logic [AW-1:0]     addr_q;
  logic [SKIP_W-1:0] skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      skip_q  <= '0;
    end else if (valid_i) begin
      unique case (state_q)
        ST_IDLE:   if (byte_i == ESC_BYTE) state_q <= ST_OPCODE;
        ST_OPCODE: begin
          if (byte_i == OP_REG_WR) begin
            state_q <= ST_ADDR;
          end else if (byte_i == OP_COPY) begin
            state_q <= ST_SKIP;
            skip_q  <= SKIP_W'(COPY_OPERANDS - 1);
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ADDR: begin
          addr_q  <= byte_i[AW-1:0];
          state_q <= ST_DATA;
        end
        ST_DATA: state_q <= ST_IDLE;
        ST_SKIP: begin
          if (skip_q == '0) state_q <= ST_IDLE;
          else              skip_q  <= skip_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en_o   = valid_i && (state_q == ST_DATA);
  assign wr_addr_o = addr_q;
  assign wr_data_o = byte_i;
  assign state_o   = state_q;
endmodule

// File: rtl/disp_shadow_regs.sv
module disp_shadow_regs
  import disp_cmd_pkg::*;
#(
  parameter int unsigned NUM_REGS = 256,
  localparam int unsigned AW = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  locked_o,
  output logic                  commit_o
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NUM_REGS - 1);

  logic [7:0] shd_q [NUM_REGS];
  logic [7:0] act_q [NUM_REGS];
  logic       locked_q, commit_q;

  logic ctrl_hit, lock_req, unlock_req, data_wr;
  assign ctrl_hit   = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign lock_req   = ctrl_hit && (wr_data_i == LOCK_VAL);
  assign unlock_req = ctrl_hit && (wr_data_i == UNLOCK_VAL);
  assign data_wr    = wr_en_i && !ctrl_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        shd_q[k] <= '0;
        act_q[k] <= '0;
      end
      locked_q <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= unlock_req;
      if (lock_req)        locked_q <= 1'b1;
      else if (unlock_req) locked_q <= 1'b0;
      if (data_wr) shd_q[wr_addr_i] <= wr_data_i;
      if (unlock_req)                  act_q <= shd_q;
      else if (data_wr && !locked_q)   act_q[wr_addr_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_pack
    assign regs_o[g*8 +: 8] = act_q[g];
  end

  assign locked_o = locked_q;
  assign commit_o = commit_q;
endmodule

// File: rtl/disp_field_map.sv
module disp_field_map #(
  parameter int unsigned NUM_REGS   = 256,
  parameter int unsigned DEPTH_REG  = 'h00,
  parameter int unsigned PCLK_REG   = 'h1B,
  parameter int unsigned BASE16_REG = 'h20,
  parameter int unsigned BASE8_REG  = 'h26
) (
  input  logic [NUM_REGS*8-1:0] regs_i,
  output logic                  depth_o,
  output logic [23:0]           base16_o,
  output logic [23:0]           base8_o,
  output logic [15:0]           pix_clk_o
);
  localparam int unsigned PTR_BYTES = 3;
  localparam int unsigned BASE_REG [2] = '{BASE16_REG, BASE8_REG};

  logic [23:0] base_w [2];

  // pointers: first register is most significant
  for (genvar p = 0; p < 2; p++) begin : g_ptr
    for (genvar b = 0; b < PTR_BYTES; b++) begin : g_byte
      assign base_w[p][(PTR_BYTES-1-b)*8 +: 8] = regs_i[(BASE_REG[p]+b)*8 +: 8];
    end
  end

  assign base16_o  = base_w[0];
  assign base8_o   = base_w[1];
  // pixel clock pair is low byte first
  assign pix_clk_o = {regs_i[(PCLK_REG+1)*8 +: 8], regs_i[PCLK_REG*8 +: 8]};
  assign depth_o   = regs_i[DEPTH_REG*8];
endmodule

// File: rtl/disp_cmd_decoder.sv
module disp_cmd_decoder
  import disp_cmd_pkg::*;
#(
  parameter int unsigned NUM_REGS = 256
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [7:0]            byte_i,
  output logic                  ready_o,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  commit_o,
  output logic                  depth_o,
  output logic [23:0]           base16_o,
  output logic [23:0]           base8_o,
  output logic [15:0]           pix_clk_o
);
  localparam int unsigned AW = $clog2(NUM_REGS);

  logic          wr_en_w;
  logic [AW-1:0] wr_addr_w;
  logic [7:0]    wr_data_w;
  logic          locked_w;
  dec_state_e    state_w;

  assign ready_o = 1'b1;

  disp_cmd_parser #(.AW(AW)) i_parser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .byte_i    (byte_i),
    .wr_en_o   (wr_en_w),
    .wr_addr_o (wr_addr_w),
    .wr_data_o (wr_data_w),
    .state_o   (state_w)
  );

  disp_shadow_regs #(.NUM_REGS(NUM_REGS)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_w),
    .wr_addr_i (wr_addr_w),
    .wr_data_i (wr_data_w),
    .regs_o    (regs_o),
    .locked_o  (locked_w),
    .commit_o  (commit_o)
  );

  disp_field_map #(.NUM_REGS(NUM_REGS)) i_fields (
    .regs_i    (regs_o),
    .depth_o   (depth_o),
    .base16_o  (base16_o),
    .base8_o   (base8_o),
    .pix_clk_o (pix_clk_o)
  );
endmodule

// File: rtl/disp_cmd_checker.sv
module disp_cmd_checker
  import disp_cmd_pkg::*;
#(
  parameter int unsigned NUM_REGS = 256,
  localparam int unsigned AW = $clog2(NUM_REGS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic [7:0]            byte_i,
  input logic [NUM_REGS*8-1:0] regs_o,
  input logic                  commit_o,
  input logic                  locked,
  input logic                  wr_en,
  input logic [AW-1:0]         wr_addr,
  input logic [7:0]            wr_data,
  input dec_state_e            state
);
  AST_LOCKED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> ($stable(regs_o) || commit_o)); // R3

  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R4

  AST_COMMIT_FROM_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(commit_o) |-> $past(wr_en && (wr_addr == AW'(NUM_REGS-1)) && (wr_data == UNLOCK_VAL))); // R4

  AST_STRAY_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && valid_i && byte_i != ESC_BYTE) |=> (state == ST_IDLE)); // R5

  AST_BAD_OPCODE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_OPCODE && valid_i && byte_i != OP_REG_WR && byte_i != OP_COPY)
      |=> (state == ST_IDLE && $stable(regs_o))); // R6

  AST_SKIP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SKIP) |-> !wr_en); // R7

  AST_CTRL_REG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_o[NUM_REGS*8-1 -: 8] == 8'h00); // R10

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(state) && $stable(regs_o))); // R11
endmodule

bind disp_cmd_decoder disp_cmd_checker #(.NUM_REGS(NUM_REGS)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .byte_i   (byte_i),
  .regs_o   (regs_o),
  .commit_o (commit_o),
  .locked   (locked_w),
  .wr_en    (wr_en_w),
  .wr_addr  (wr_addr_w),
  .wr_data  (wr_data_w),
  .state    (state_w)
);

// File: tb/test_disp_cmd_decoder.sv
`timescale 1ns/1ps
module test_disp_cmd_decoder;
  localparam int NR = 256;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [7:0]    byte_i = 8'h00;
  logic          ready_o, commit_o, depth_o;
  logic [NR*8-1:0] regs_o;
  logic [23:0]   base16_o, base8_o;
  logic [15:0]   pix_clk_o;

  disp_cmd_decoder #(.NUM_REGS(NR)) i_disp_cmd_decoder (
    .clk_i, .rst_ni, .valid_i, .byte_i, .ready_o, .regs_o, .commit_o,
    .depth_o, .base16_o, .base8_o, .pix_clk_o
  );

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  // reference model
  logic [7:0] m_act [NR];
  logic [7:0] m_shd [NR];
  bit  m_locked = 0;
  bit  m_commit = 0;
  int  m_st = 0;   // 0 idle, 1 opcode, 2 addr, 3 data, 4 skip
  int  m_skip = 0;
  int  m_addr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_byte(input logic [7:0] b);
    m_commit = 0;
    case (m_st)
      0: if (b == 8'hAF) m_st = 1;
      1: if (b == 8'h20) m_st = 2;
         else if (b == 8'h6A) begin m_st = 4; m_skip = 7; end
         else m_st = 0;
      2: begin m_addr = b; m_st = 3; end
      3: begin
        m_st = 0;
        if (m_addr == NR-1) begin
          if (b == 8'h00) m_locked = 1;
          else if (b == 8'hFF) begin
            m_locked = 0;
            for (int i = 0; i < NR; i++) m_act[i] = m_shd[i];
            m_commit = 1;
          end
        end else begin
          m_shd[m_addr] = b;
          if (!m_locked) m_act[m_addr] = b;
        end
      end
      default: begin m_skip--; if (m_skip == 0) m_st = 0; end
    endcase
  endtask

  task automatic compare_cycle();
    int bad = -1;
    for (int i = 0; i < NR; i++)
      if (regs_o[i*8 +: 8] !== m_act[i] && bad < 0) bad = i;
    chk(bad < 0, cur_req, (bad < 0) ? 32'h0 : {bad[15:0], 8'h0, regs_o[bad*8 +: 8]},
        (bad < 0) ? 32'h0 : {bad[15:0], 8'h0, m_act[bad]});
    chk(commit_o === m_commit, cur_req, {31'h0, commit_o}, {31'h0, m_commit});
    chk(ready_o === 1'b1, "R1 ready", {31'h0, ready_o}, 32'h1);
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic step(input logic v, input logic [7:0] b);
    valid_i = v;
    byte_i  = b;
    @(posedge clk_i);
    if (v) model_byte(b);
    else   m_commit = 0;
    @(negedge clk_i);
    compare_cycle();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1, 8'hAF); step(1, 8'h20); step(1, a); step(1, d);
  endtask

  function automatic logic [7:0] reg_of(input int a);
    return regs_o[a*8 +: 8];
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin m_act[i] = 8'h00; m_shd[i] = 8'h00; end
    repeat (3) @(negedge clk_i);
    // R1: reset state
    cur_req = "R1";
    compare_cycle();
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_cycle();

    // R2 and R9/R8 fields, unlocked writes
    cur_req = "R2";
    wr(8'h00, 8'h01);
    chk(reg_of(0) == 8'h01, "R2 reg00", {24'h0, reg_of(0)}, 32'h01);
    chk(depth_o == 1'b1, "R9 depth 24bpp", {31'h0, depth_o}, 32'h1);
    wr(8'h1B, 8'h34);
    wr(8'h1C, 8'h12);
    chk(pix_clk_o == 16'h1234, "R9 pixclk low-first", {16'h0, pix_clk_o}, 32'h1234);
    wr(8'h20, 8'hA1); wr(8'h21, 8'hB2); wr(8'h22, 8'hC3);
    chk(base16_o == 24'hA1B2C3, "R8 base16", {8'h0, base16_o}, 32'hA1B2C3);
    wr(8'h26, 8'h0D); wr(8'h27, 8'h0E); wr(8'h28, 8'h0F);
    chk(base8_o == 24'h0D0E0F, "R8 base8", {8'h0, base8_o}, 32'h0D0E0F);
    wr(8'h00, 8'h00);
    chk(depth_o == 1'b0, "R9 depth 16bpp", {31'h0, depth_o}, 32'h0);

    // R11: idle cycles with junk on byte_i between command bytes
    cur_req = "R11";
    step(1, 8'hAF); step(0, 8'h6A); step(1, 8'h20); step(0, 8'hAF);
    step(1, 8'h40); step(0, 8'hFF); step(1, 8'h5C);
    chk(reg_of(8'h40) == 8'h5C, "R11 gaps", {24'h0, reg_of(8'h40)}, 32'h5C);

    // R5: stray bytes dropped
    cur_req = "R5";
    step(1, 8'h20); step(1, 8'h41); step(1, 8'h77); step(1, 8'h00);
    wr(8'h41, 8'h99);
    chk(reg_of(8'h41) == 8'h99, "R5 after stray", {24'h0, reg_of(8'h41)}, 32'h99);

    // R6: unknown opcode, including 0xAF as opcode
    cur_req = "R6";
    step(1, 8'hAF); step(1, 8'h33); step(1, 8'h10); step(1, 8'h77);
    chk(reg_of(8'h10) == 8'h00, "R6 no write", {24'h0, reg_of(8'h10)}, 32'h0);
    step(1, 8'hAF); step(1, 8'hAF); step(1, 8'h20); step(1, 8'h11); step(1, 8'h66);
    chk(reg_of(8'h11) == 8'h00, "R6 AF opcode", {24'h0, reg_of(8'h11)}, 32'h0);
    wr(8'h10, 8'h77);
    chk(reg_of(8'h10) == 8'h77, "R6 resume", {24'h0, reg_of(8'h10)}, 32'h77);

    // R7: copy operands skipped
    cur_req = "R7";
    step(1, 8'hAF); step(1, 8'h6A);
    step(1, 8'hAF); step(1, 8'h20); step(1, 8'h05); step(1, 8'hAF);
    step(1, 8'h20); step(1, 8'h05); step(1, 8'h99);
    chk(reg_of(5) == 8'h00, "R7 operands", {24'h0, reg_of(5)}, 32'h0);
    wr(8'h06, 8'h42);
    chk(reg_of(6) == 8'h42, "R7 resume", {24'h0, reg_of(6)}, 32'h42);

    // R10: control register with other value
    cur_req = "R10";
    wr(8'hFF, 8'h5A);
    chk(reg_of(NR-1) == 8'h00, "R10 ctrl reads 0", {24'h0, reg_of(NR-1)}, 32'h0);
    wr(8'h07, 8'h3C);
    chk(reg_of(7) == 8'h3C, "R10 still unlocked", {24'h0, reg_of(7)}, 32'h3C);

    // R3: locked writes go to shadow only
    cur_req = "R3";
    wr(8'hFF, 8'h00);
    wr(8'h20, 8'h11); wr(8'h21, 8'h22); wr(8'h22, 8'h33);
    wr(8'h1B, 8'h88); wr(8'h07, 8'hE1);
    chk(base16_o == 24'hA1B2C3, "R3 base16 frozen", {8'h0, base16_o}, 32'hA1B2C3);
    chk(reg_of(7) == 8'h3C, "R3 reg07 frozen", {24'h0, reg_of(7)}, 32'h3C);
    wr(8'hFF, 8'h5A);  // R10 while locked: stays locked
    wr(8'h08, 8'h18);
    chk(reg_of(8) == 8'h00, "R10 lock kept", {24'h0, reg_of(8)}, 32'h0);

    // R4: unlock commits all at once with a one-cycle strobe
    cur_req = "R4";
    step(1, 8'hAF); step(1, 8'h20); step(1, 8'hFF);
    valid_i = 1; byte_i = 8'hFF;
    @(posedge clk_i); model_byte(8'hFF);
    @(negedge clk_i);
    compare_cycle();
    chk(commit_o == 1'b1, "R4 strobe", {31'h0, commit_o}, 32'h1);
    chk(base16_o == 24'h112233, "R4 base16 committed", {8'h0, base16_o}, 32'h112233);
    chk(pix_clk_o == 16'h1288, "R4 pixclk committed", {16'h0, pix_clk_o}, 32'h1288);
    chk(reg_of(8) == 8'h18 && reg_of(7) == 8'hE1, "R4 regs committed",
        {16'h0, reg_of(8), reg_of(7)}, 32'h18E1);
    step(0, 8'h00);
    chk(commit_o == 1'b0, "R4 strobe one cycle", {31'h0, commit_o}, 32'h0);

    // R4: unlock while unlocked still strobes
    wr(8'hFF, 8'hFF);
    chk(commit_o == 1'b1, "R4 unlock when open", {31'h0, commit_o}, 32'h1);
    step(0, 8'h00);

    // R2: post-commit unlocked write lands immediately
    cur_req = "R2";
    wr(8'h30, 8'h5E);
    chk(reg_of(8'h30) == 8'h5E, "R2 after commit", {24'h0, reg_of(8'h30)}, 32'h5E);

    repeat (2) step(0, 8'h00);
    summary();
    $finish;
  end
endmodule